// File: doc/BRIEF.md
# Contiguous-Region Leaf Entry Fixer

This block sits at the end of a hardware page-table walker and post-processes every 64-bit leaf entry that the walker has fetched. An entry whose top bit (bit 63) is clear is handed on untouched. When that bit is set on a leaf, the entry claims to map one naturally aligned, contiguous run of base pages. The size of the run is coded in the lowest 9-bit page-number field (entry bits 18:10): the position of the lowest set bit gives the order. Only order 4 (low nibble `1000`, a 64 KiB run of 4 KiB pages) is accepted, and only at walk level 0.

For an accepted entry, the block rebuilds the physical page number. It copies the low `order` bits of the level-0 virtual page number over the matching low bits of the entry, so that the result points at the exact 4 KiB page inside the run. It also reports the run size as a log2 byte count. Any other flagged leaf is a reserved encoding: the block raises a fault strobe in place of a translation.

Results are registered. They appear one clock after the input strobe and hold until the next strobe. Fetching entries, checking permissions and storing translations are left to the surrounding walker.

Top module: `napot_pte_fixer`

## Requirements
- R1: `out_valid` is 0 during reset and goes high exactly one clock after each cycle with `in_valid` high. It is low one clock after each cycle with `in_valid` low. All result outputs are 0 after reset.
- R2: An entry with bit 63 clear passes through unchanged, with `out_fault`=0 and `out_napot`=0. `out_size_log2` is then 12+9×level.
- R3: A leaf (bit 1 or bit 3 set) with bit 63 set, at level 0, whose bits 13:10 are `1000`, is accepted. `out_pte` equals the input with bits 13:10 replaced by `in_vpn[3:0]` and all other bits kept. `out_napot`=1, `out_fault`=0 and `out_size_log2`=16.
- R4: A leaf with bit 63 set at level 0 is reserved and faults when its lowest set bit in bits 18:10 is at a field index other than 3. This covers the patterns `xxx1`, `xx10`, `x100` and `xxx1_0000`, higher positions, and an all-zero field.
- R5: A leaf with bit 63 set at any level other than 0 faults, whatever its page-number bits.
- R6: On a fault, `out_pte` equals the input entry, `out_napot`=0 and `out_size_log2`=0.
- R7: A non-leaf entry (bits 1 and 3 both clear) with bit 63 set passes through as in R2, with no fault. This leaves bits 5:0 of every entry unchanged in every case.
- R8: While `in_valid` is low, `out_pte`, `out_fault`, `out_napot` and `out_size_log2` hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe: an entry is presented this cycle |
| in_pte | input | 64 | Fetched page-table entry |
| in_level | input | 2 | Walk level at which the entry was found |
| in_vpn | input | 27 | Virtual page number, three 9-bit level fields, level 0 lowest |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_pte | output | 64 | Corrected or passed-through entry |
| out_fault | output | 1 | Reserved encoding: raise a page fault |
| out_napot | output | 1 | Entry was an accepted contiguous-run leaf |
| out_size_log2 | output | 6 | log2 of mapped bytes; 0 on fault |

## Verification
Each result is due at the first rising edge after its input strobe, and a single register stage lies on the path. The bench therefore drives an entry on a falling edge, drops the strobe on the next falling edge and compares every output there, half a clock after the capture edge. On the falling edge after that, just before the next entry is driven, it checks that `out_valid` has returned low and that the data outputs still hold. This confirms both the one-cycle strobe and the hold behaviour without sampling at an active edge.

// File: rtl/napot_pkg.sv
package napot_pkg;

  // Default geometry of a three-level 64-bit entry format.
  localparam int PTE_W     = 64;
  localparam int VPN_W     = 9;
  localparam int LEVELS    = 3;
  localparam int LVL_W     = 2;
  localparam int PPN0_LSB  = 10;
  localparam int FLAG_BIT  = 63;
  localparam int PAGE_SHIFT = 12;
  localparam int SIZE_W    = 6;

  // Bit positions of the read and execute permissions; either marks a leaf.
  localparam int READ_BIT  = 1;
  localparam int EXEC_BIT  = 3;

  typedef enum logic [1:0] {
    VERDICT_PASS   = 2'd0,
    VERDICT_SPLICE = 2'd1,
    VERDICT_FAULT  = 2'd2
  } verdict_e;

endpackage

// File: rtl/napot_decode.sv
module napot_decode
  import napot_pkg::*;
#(
  parameter int PTE_W_P    = PTE_W,
  parameter int FIELD_W    = VPN_W,
  parameter int FIELD_LSB  = PPN0_LSB,
  parameter int LVL_W_P    = LVL_W,
  parameter int FLAG_POS   = FLAG_BIT,
  parameter int unsigned SUPPORTED = 32'h0000_0010,
  localparam int ORD_W     = $clog2(FIELD_W + 1)
) (
  input  logic [PTE_W_P-1:0] pte,
  input  logic [LVL_W_P-1:0] level,
  output logic               is_leaf,
  output logic               flagged,
  output logic [ORD_W-1:0]   order,
  output verdict_e           verdict
);

  localparam int SUP_N = 1 << ORD_W;
  localparam logic [SUP_N-1:0] SUP_VEC = SUP_N'(SUPPORTED);

  // Order is one more than the index of the lowest set bit; 0 when none.
  function automatic logic [ORD_W-1:0] lowest_order(input logic [FIELD_W-1:0] f);
    logic [ORD_W-1:0] r;
    r = '0;
    for (int k = FIELD_W - 1; k >= 0; k--) begin
      if (f[k]) r = ORD_W'(k + 1);
    end
    return r;
  endfunction

  logic [FIELD_W-1:0] field;
  logic               order_ok;
  logic               level_zero;

  assign field      = pte[FIELD_LSB +: FIELD_W];
  assign is_leaf    = pte[READ_BIT] | pte[EXEC_BIT];
  assign flagged    = pte[FLAG_POS];
  assign order      = lowest_order(field);
  assign order_ok   = (order != '0) && SUP_VEC[order];
  assign level_zero = (level == '0);

  always_comb begin
    if (!(flagged && is_leaf))          verdict = VERDICT_PASS;
    else if (level_zero && order_ok)    verdict = VERDICT_SPLICE;
    else                                verdict = VERDICT_FAULT;
  end

endmodule

// File: rtl/napot_splice.sv
module napot_splice
  import napot_pkg::*;
#(
  parameter int PTE_W_P   = PTE_W,
  parameter int FIELD_W   = VPN_W,
  parameter int FIELD_LSB = PPN0_LSB,
  localparam int ORD_W    = $clog2(FIELD_W + 1)
) (
  input  logic [PTE_W_P-1:0] pte,
  input  logic [FIELD_W-1:0] vpn0,
  input  logic [ORD_W-1:0]   order,
  input  logic               enable,
  output logic [PTE_W_P-1:0] pte_out
);

  localparam int HI_LSB = FIELD_LSB + FIELD_W;

  logic [FIELD_W-1:0] field_new;

  // Each page-number bit below the order comes from the virtual page number.
  for (genvar b = 0; b < FIELD_W; b++) begin : g_bit
    logic take_va;
    assign take_va      = enable && (int'(order) > b);
    assign field_new[b] = take_va ? vpn0[b] : pte[FIELD_LSB + b];
  end

  assign pte_out = {pte[PTE_W_P-1:HI_LSB], field_new, pte[FIELD_LSB-1:0]};

endmodule

// File: rtl/napot_pte_fixer.sv
module napot_pte_fixer
  import napot_pkg::*;
#(
  parameter int PTE_W_P   = PTE_W,
  parameter int FIELD_W   = VPN_W,
  parameter int NUM_LVL   = LEVELS,
  parameter int LVL_W_P   = LVL_W,
  parameter int FIELD_LSB = PPN0_LSB,
  parameter int FLAG_POS  = FLAG_BIT,
  parameter int SIZE_W_P  = SIZE_W,
  parameter int unsigned SUPPORTED = 32'h0000_0010,
  localparam int VA_W     = NUM_LVL * FIELD_W,
  localparam int ORD_W    = $clog2(FIELD_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [PTE_W_P-1:0]  in_pte,
  input  logic [LVL_W_P-1:0]  in_level,
  input  logic [VA_W-1:0]     in_vpn,
  output logic                out_valid,
  output logic [PTE_W_P-1:0]  out_pte,
  output logic                out_fault,
  output logic                out_napot,
  output logic [SIZE_W_P-1:0] out_size_log2
);

  // Mapped size: base page grows by one field per level; a run adds its order.
  function automatic logic [SIZE_W_P-1:0] region_log2(
    input verdict_e           v,
    input logic [LVL_W_P-1:0] lvl,
    input logic [ORD_W-1:0]   ord
  );
    case (v)
      VERDICT_SPLICE: return SIZE_W_P'(PAGE_SHIFT) + SIZE_W_P'(ord);
      VERDICT_FAULT:  return '0;
      default:        return SIZE_W_P'(PAGE_SHIFT + FIELD_W * int'(lvl));
    endcase
  endfunction

  logic                dec_leaf;
  logic                dec_flag;
  logic [ORD_W-1:0]    dec_order;
  verdict_e            dec_verdict;
  logic                dec_ok;
  logic                dec_bad;
  logic [PTE_W_P-1:0]  spliced_pte;
  logic [SIZE_W_P-1:0] next_size;

  napot_decode #(
    .PTE_W_P   (PTE_W_P),
    .FIELD_W   (FIELD_W),
    .FIELD_LSB (FIELD_LSB),
    .LVL_W_P   (LVL_W_P),
    .FLAG_POS  (FLAG_POS),
    .SUPPORTED (SUPPORTED)
  ) u_decode (
    .pte     (in_pte),
    .level   (in_level),
    .is_leaf (dec_leaf),
    .flagged (dec_flag),
    .order   (dec_order),
    .verdict (dec_verdict)
  );

  assign dec_ok  = (dec_verdict == VERDICT_SPLICE);
  assign dec_bad = (dec_verdict == VERDICT_FAULT);

  napot_splice #(
    .PTE_W_P   (PTE_W_P),
    .FIELD_W   (FIELD_W),
    .FIELD_LSB (FIELD_LSB)
  ) u_splice (
    .pte     (in_pte),
    .vpn0    (in_vpn[FIELD_W-1:0]),
    .order   (dec_order),
    .enable  (dec_ok),
    .pte_out (spliced_pte)
  );

  assign next_size = region_log2(dec_verdict, in_level, dec_order);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid     <= 1'b0;
      out_pte       <= '0;
      out_fault     <= 1'b0;
      out_napot     <= 1'b0;
      out_size_log2 <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_pte       <= spliced_pte;
        out_fault     <= dec_bad;
        out_napot     <= dec_ok;
        out_size_log2 <= next_size;
      end
    end
  end

  // R1: strobe follows the input strobe by one clock
  assert_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  // R2: unflagged entries come out as they went in
  assert_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_pte[FLAG_POS]) |=>
      (out_pte == $past(in_pte)) && !out_fault && !out_napot);

  // R3: accepted runs report their size and no fault
  assert_splice_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && dec_ok) |=>
      out_napot && !out_fault &&
      (out_size_log2 == SIZE_W_P'(PAGE_SHIFT) + SIZE_W_P'($past(dec_order))));

  // R5: flagged leaves above level 0 always fault
  assert_upper_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_pte[FLAG_POS] && dec_leaf && (in_level != '0)) |=> out_fault);

  // R6: a fault carries no run and no size
  assert_fault_clean_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fault) |-> (!out_napot && (out_size_log2 == '0)));

  // R8: results hold while no entry is presented
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_pte) && $stable(out_fault) &&
                   $stable(out_napot) && $stable(out_size_log2)));

endmodule

// File: tb/napot_pte_fixer_tb.sv
module napot_pte_fixer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [63:0] in_pte;
  logic [1:0]  in_level;
  logic [26:0] in_vpn;
  logic        out_valid;
  logic [63:0] out_pte;
  logic        out_fault;
  logic        out_napot;
  logic [5:0]  out_size_log2;

  int checks;
  int failures;
  int cycles;
  logic [63:0] seed;
  logic [63:0] last_pte;
  logic        have_last;

  napot_pte_fixer u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_pte        (in_pte),
    .in_level      (in_level),
    .in_vpn        (in_vpn),
    .out_valid     (out_valid),
    .out_pte       (out_pte),
    .out_fault     (out_fault),
    .out_napot     (out_napot),
    .out_size_log2 (out_size_log2)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      failures = failures + 1;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [63:0] xorshift(input logic [63:0] s);
    logic [63:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 7);
    x = x ^ (x << 17);
    return x;
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks = checks + 1;
    if (!ok) begin
      failures = failures + 1;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Present one entry, then compare the result half a clock after capture.
  task automatic apply(input logic [63:0] pte, input logic [1:0] lvl,
                       input logic [26:0] vpn, input string req);
    logic        leaf, flag, good;
    logic [8:0]  fld;
    logic [63:0] e_pte;
    logic        e_fault, e_napot;
    logic [5:0]  e_size;
    @(negedge clk);
    if (have_last) begin
      // R8 and R1: idle cycle leaves the strobe low and data held
      check(out_valid == 1'b0, "R1", "strobe low after idle", 64'(out_valid), 64'd0);
      check(out_pte == last_pte, "R8", "hold while idle", out_pte, last_pte);
    end
    in_valid = 1'b1;
    in_pte   = pte;
    in_level = lvl;
    in_vpn   = vpn;
    leaf = pte[1] | pte[3];
    flag = pte[63];
    fld  = pte[18:10];
    good = (lvl == 2'd0) && ((fld % 16) == 9'd8);
    if (!(flag && leaf)) begin
      e_pte = pte; e_fault = 1'b0; e_napot = 1'b0;
      e_size = 6'(12 + 9 * int'(lvl));
    end else if (good) begin
      e_pte = (pte & ~(64'hF << 10)) | (64'(vpn[3:0]) << 10);
      e_fault = 1'b0; e_napot = 1'b1; e_size = 6'd16;
    end else begin
      e_pte = pte; e_fault = 1'b1; e_napot = 1'b0; e_size = 6'd0;
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R1", "strobe one clock later", 64'(out_valid), 64'd1);
    check(out_pte == e_pte && out_fault == e_fault && out_napot == e_napot &&
          out_size_log2 == e_size, req,
          "pte/fault/napot/size",
          {out_pte[55:0], out_size_log2, out_fault, out_napot},
          {e_pte[55:0], e_size, e_fault, e_napot});
    last_pte  = e_pte;
    have_last = 1'b1;
  endtask

  initial begin
    checks = 0; failures = 0; cycles = 0;
    seed = 64'h9E37_79B9_7F4A_7C15;
    have_last = 1'b0;
    last_pte  = '0;
    rst_n = 1'b0; in_valid = 1'b0; in_pte = '0; in_level = '0; in_vpn = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0 && out_pte == '0 && out_fault == 1'b0 &&
          out_napot == 1'b0 && out_size_log2 == '0, "R1", "reset state",
          out_pte, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3/R4: every value of the level-0 page-number field on a flagged leaf
    for (int p = 0; p < 512; p++) begin
      for (int v = 0; v < 2; v++) begin
        logic [63:0] pte;
        string tag;
        seed = xorshift(seed);
        pte = seed;
        pte[63] = 1'b1;
        pte[1]  = 1'b1;
        pte[18:10] = 9'(p);
        tag = ((p % 16) == 8) ? "R3" : "R4";
        apply(pte, 2'd0, 27'(xorshift(seed ^ 64'(v))), tag);
      end
    end

    // R5/R6: flagged leaves at higher levels, including the accepted pattern
    for (int lvl = 1; lvl < 4; lvl++) begin
      for (int p = 0; p < 48; p++) begin
        logic [63:0] pte;
        seed = xorshift(seed);
        pte = seed;
        pte[63] = 1'b1;
        pte[3]  = 1'b1;
        pte[18:10] = (p < 16) ? 9'(p * 16 + 8) : seed[40:32];
        apply(pte, 2'(lvl), seed[26:0], (p % 2 == 0) ? "R5" : "R6");
      end
    end

    // R2: unflagged entries at every level
    for (int n = 0; n < 200; n++) begin
      logic [63:0] pte;
      seed = xorshift(seed);
      pte = seed;
      pte[63] = 1'b0;
      if (n % 4 == 0) pte[13:10] = 4'b1000;
      apply(pte, seed[45:44], seed[38:12], "R2");
    end

    // R7: flagged non-leaf entries pass untouched
    for (int n = 0; n < 64; n++) begin
      logic [63:0] pte;
      seed = xorshift(seed);
      pte = seed;
      pte[63] = 1'b1;
      pte[1]  = 1'b0;
      pte[3]  = 1'b0;
      if (n % 2 == 0) pte[13:10] = 4'b1000;
      apply(pte, 2'(n % 4), seed[50:24], "R7");
    end

    // R8: back-to-back idle cycles keep the last result
    repeat (3) begin
      @(negedge clk);
      check(out_pte == last_pte, "R8", "hold over idle run", out_pte, last_pte);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule